// File: doc/BRIEF.md
# Two-Rail Serial Word Receiver

This block receives one avionics-style return-to-zero serial stream and turns it into a parallel word that a host reads back. The line arrives as two logic-level rails. A pulse on the one-rail carries a 1 bit and a pulse on the zero-rail carries a 0 bit. Between bits both rails return low. The block samples the rails on every clock, and that clock runs at ten times the bit rate. The incoming stream is asynchronous to the clock, so both rails pass through a two-stage synchronizer first.

Recovered bits fill a word least significant bit first. The word length is selectable as 25 or 32 bits, and the bit counter restarts on a long null. When the last bit arrives, the word is latched together with a parity status bit, and a ready flag rises. The host fetches the word as two 16-bit halves over an enable-gated bus. Reading the upper half clears the flag.

Top module: `arx_receiver`

## Requirements
- R1: A bit is accepted when one rail is high and the other low for at least 3 consecutive samples. A one-rail pulse gives 1 and a zero-rail pulse gives 0. A qualifying pulse of 2 samples or fewer adds no bit.
- R2: When both rails are low for 20 consecutive samples, the bit counter restarts at zero and any partial word is discarded.
- R3: The first received bit of a word lands in word bit 0, and each later bit lands one position higher.
- R4: With `len_short`=0 a word is 32 bits long. With `len_short`=1 it is 25 bits long, and latched bits 31..25 read as 0.
- R5: The parity status bit is 1 when the received word held an even number of ones, and 0 when the count was odd.
- R6: With `rd_sel`=0 the bus carries {word[14:8], status, word[7:0]}, so the status sits on bus bit 8. With `rd_sel`=1 the bus carries word[30:15].
- R7: `data_ready` rises on the clock edge after the last bit of a word is accepted, and it stays high until the word is fetched.
- R8: A cycle with `rd_en`=1 and `rd_sel`=1 clears `data_ready` on the next edge. Reading only the lower half leaves it set.
- R9: While `rd_en`=0 the bus output is all zeros.
- R10: A word that completes while `data_ready` is still set replaces the latched word.
- R11: Samples with both rails high add no bit and restart the pulse qualification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, ten times the bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| rail_one | input | 1 | Line rail pulsed for a 1 bit (asynchronous) |
| rail_zero | input | 1 | Line rail pulsed for a 0 bit (asynchronous) |
| len_short | input | 1 | Word length select: 0 for 32 bits, 1 for 25 bits |
| rd_en | input | 1 | Bus output enable |
| rd_sel | input | 1 | Half select: 0 for the lower half with status, 1 for the upper half |
| bus_out | output | 16 | Read data bus |
| data_ready | output | 1 | A latched word is waiting to be fetched |

## Verification
Every cycle, the assertions check the following:
- bit and null events never coincide;
- every accepted bit coincides with exactly one rail high;
- a null or a completed word returns the bit counter to zero;
- the first bit lands in bit 0;
- the ready flag rises after a completed word and falls after an upper-half read;
- the latch changes only when a word completes.

Other behaviour can only be shown by the bench's scenarios. These are the correct word values for both lengths, the parity status for odd and even counts, the half-word layout, and the rejection of short pulses and both-high samples. They also include the discarding of a partial word cut off by a null, and the overwrite of an unread word.

// File: rtl/arx_pkg.sv
package arx_pkg;
  localparam int ARX_WORD_W = 32;
  localparam int ARX_HALF_W = 16;
  localparam int ARX_LONG_LEN = 32;
  localparam int ARX_SHORT_LEN = 25;
  localparam int ARX_CNT_W = $clog2(ARX_WORD_W + 1);

  typedef logic [ARX_WORD_W-1:0] arx_word_t;
  typedef logic [ARX_HALF_W-1:0] arx_half_t;

  function automatic logic [ARX_CNT_W-1:0] arx_word_len(input logic short_sel);
    return short_sel ? ARX_CNT_W'(ARX_SHORT_LEN) : ARX_CNT_W'(ARX_LONG_LEN);
  endfunction

  // 1 when the number of ones is even
  function automatic logic arx_even_status(input arx_word_t w);
    return ~(^w);
  endfunction

  function automatic arx_half_t arx_half(input arx_word_t w, input logic st,
                                         input logic upper);
    if (upper) return w[30:15];
    return {w[14:8], st, w[7:0]};
  endfunction
endpackage

// File: rtl/arx_rail_sampler.sv
module arx_rail_sampler #(
  parameter int MIN_PULSE = 3,
  parameter int NULL_SAMPLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rail_one,
  input  logic rail_zero,
  output logic bit_evt,
  output logic bit_val,
  output logic gap_evt
);
  localparam int PW = $clog2(MIN_PULSE + 1);
  localparam int NW = $clog2(NULL_SAMPLES + 1);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] one_sync, zero_sync;
  logic one_s, zero_s;
  logic [PW-1:0] one_cnt, zero_cnt;
  logic [NW-1:0] null_cnt;
  logic one_q, zero_q, null_q;
  logic one_hit, zero_hit, null_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      one_sync  <= '0;
      zero_sync <= '0;
    end else begin
      one_sync  <= {one_sync[SYNC_STAGES-2:0], rail_one};
      zero_sync <= {zero_sync[SYNC_STAGES-2:0], rail_zero};
    end
  end

  assign one_s  = one_sync[SYNC_STAGES-1];
  assign zero_s = zero_sync[SYNC_STAGES-1];

  assign one_q  = one_s && !zero_s;
  assign zero_q = zero_s && !one_s;
  assign null_q = !one_s && !zero_s;

  assign one_hit  = one_q  && (one_cnt  == PW'(MIN_PULSE - 1));
  assign zero_hit = zero_q && (zero_cnt == PW'(MIN_PULSE - 1));
  assign null_hit = null_q && (null_cnt == NW'(NULL_SAMPLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      one_cnt  <= '0;
      zero_cnt <= '0;
      null_cnt <= '0;
    end else begin
      if (!one_q) one_cnt <= '0;
      else if (one_cnt != PW'(MIN_PULSE)) one_cnt <= one_cnt + 1'b1;
      if (!zero_q) zero_cnt <= '0;
      else if (zero_cnt != PW'(MIN_PULSE)) zero_cnt <= zero_cnt + 1'b1;
      if (!null_q) null_cnt <= '0;
      else if (null_cnt != NW'(NULL_SAMPLES)) null_cnt <= null_cnt + 1'b1;
    end
  end

  assign bit_evt = one_hit || zero_hit;
  assign bit_val = one_hit;
  assign gap_evt = null_hit;

  AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_evt && gap_evt)); // R11
  AST_BIT_ONE_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
    bit_evt |-> (one_s ^ zero_s)); // R1
  AST_BIT_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    bit_evt |-> $past(one_s ^ zero_s)); // R1
endmodule

// File: rtl/arx_framer.sv
module arx_framer
  import arx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      len_short,
  input  logic      bit_evt,
  input  logic      bit_val,
  input  logic      gap_evt,
  output logic      word_done,
  output arx_word_t word_full
);
  logic [ARX_CNT_W-1:0] bit_cnt;
  logic [ARX_CNT_W-1:0] word_len;
  arx_word_t            acc;
  logic                 last_bit;

  assign word_len  = arx_word_len(len_short);
  assign last_bit  = (bit_cnt == word_len - 1'b1);
  assign word_done = bit_evt && last_bit;
  assign word_full = acc | (arx_word_t'(bit_val) << bit_cnt[4:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      acc     <= '0;
    end else if (gap_evt) begin
      bit_cnt <= '0;
      acc     <= '0;
    end else if (bit_evt) begin
      if (last_bit || bit_cnt >= word_len) begin
        bit_cnt <= '0;
        acc     <= '0;
      end else begin
        acc[bit_cnt[4:0]] <= bit_val;
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  AST_GAP_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    gap_evt |=> (bit_cnt == '0 && acc == '0)); // R2
  AST_DONE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> (bit_cnt == '0)); // R4
  AST_FIRST_BIT_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_evt && bit_cnt == '0 && !word_done) |=> (acc[0] == $past(bit_val))); // R3
endmodule

// File: rtl/arx_latch_port.sv
module arx_latch_port
  import arx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      word_done,
  input  arx_word_t word_full,
  input  logic      rd_en,
  input  logic      rd_sel,
  output arx_half_t bus_out,
  output logic      data_ready
);
  arx_word_t lat_word;
  logic      lat_status;
  logic      fetch_done;

  assign fetch_done = rd_en && rd_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_word   <= '0;
      lat_status <= 1'b0;
      data_ready <= 1'b0;
    end else begin
      if (word_done) begin
        lat_word   <= word_full;
        lat_status <= arx_even_status(word_full);
        data_ready <= 1'b1;
      end else if (fetch_done) begin
        data_ready <= 1'b0;
      end
    end
  end

  assign bus_out = rd_en ? arx_half(lat_word, lat_status, rd_sel) : '0;

  AST_READY_ON_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> data_ready); // R7
  AST_READY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ready && fetch_done && !word_done) |=> !data_ready); // R8
  AST_LOWER_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ready && rd_en && !rd_sel) |=> data_ready); // R8
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !word_done |=> $stable(lat_word)); // R10
endmodule

// File: rtl/arx_receiver.sv
module arx_receiver
  import arx_pkg::*;
#(
  parameter int MIN_PULSE = 3,
  parameter int NULL_SAMPLES = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rail_one,
  input  logic        rail_zero,
  input  logic        len_short,
  input  logic        rd_en,
  input  logic        rd_sel,
  output logic [15:0] bus_out,
  output logic        data_ready
);
  logic      bit_evt, bit_val, gap_evt, word_done;
  arx_word_t word_full;

  arx_rail_sampler #(.MIN_PULSE(MIN_PULSE), .NULL_SAMPLES(NULL_SAMPLES)) u_sampler (
    .clk(clk), .rst_n(rst_n), .rail_one(rail_one), .rail_zero(rail_zero),
    .bit_evt(bit_evt), .bit_val(bit_val), .gap_evt(gap_evt));

  arx_framer u_framer (
    .clk(clk), .rst_n(rst_n), .len_short(len_short), .bit_evt(bit_evt),
    .bit_val(bit_val), .gap_evt(gap_evt), .word_done(word_done),
    .word_full(word_full));

  arx_latch_port u_port (
    .clk(clk), .rst_n(rst_n), .word_done(word_done), .word_full(word_full),
    .rd_en(rd_en), .rd_sel(rd_sel), .bus_out(bus_out), .data_ready(data_ready));

  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (bus_out == '0)); // R9
endmodule

// File: tb/arx_receiver_bench.sv
module arx_receiver_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rail_one = 1'b0, rail_zero = 1'b0, len_short = 1'b0;
  logic rd_en = 1'b0, rd_sel = 1'b0;
  logic [15:0] bus_out;
  logic data_ready;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  arx_receiver u_arx_receiver (
    .clk(clk), .rst_n(rst_n), .rail_one(rail_one), .rail_zero(rail_zero),
    .len_short(len_short), .rd_en(rd_en), .rd_sel(rd_sel),
    .bus_out(bus_out), .data_ready(data_ready));

  // {len_short, word}
  localparam logic [32:0] VECS [6] = '{
    {1'b0, 32'h0000_0000}, {1'b0, 32'hFFFF_FFFF}, {1'b0, 32'hA5A5_0F3C},
    {1'b0, 32'h8000_0001}, {1'b1, 32'h01FF_FFFF}, {1'b1, 32'hF123_4567}};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] masked(input logic [31:0] w, input logic s);
    return s ? (w & 32'h01FF_FFFF) : w;
  endfunction

  function automatic logic [15:0] exp_half(input logic [31:0] w, input logic s, input logic up);
    logic [31:0] m;
    int ones;
    m = masked(w, s);
    ones = $countones(m);
    if (up) return m[30:15];
    return {m[14:8], (ones % 2 == 0), m[7:0]};
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    rail_one = b; rail_zero = !b;
    idle(4);
    @(negedge clk);
    rail_one = 1'b0; rail_zero = 1'b0;
    idle(4);
  endtask

  task automatic send_bits(input logic [31:0] w, input int n);
    for (int i = 0; i < n; i++) send_bit(w[i]);
  endtask

  task automatic send_word(input logic [31:0] w, input logic s);
    len_short = s;
    send_bits(w, s ? 25 : 32);
    idle(40);
  endtask

  task automatic read_check(input string req, input logic [31:0] w, input logic s);
    @(negedge clk);
    check({req, " ready"}, {31'b0, data_ready}, 32'd1);
    rd_en = 1'b1; rd_sel = 1'b0;
    #1 check({req, " lower"}, {16'b0, bus_out}, {16'b0, exp_half(w, s, 1'b0)});
    rd_sel = 1'b1;
    #1 check({req, " upper"}, {16'b0, bus_out}, {16'b0, exp_half(w, s, 1'b1)});
    @(negedge clk);
    rd_en = 1'b0; rd_sel = 1'b0;
    check("R8 ready cleared", {31'b0, data_ready}, 32'd0);
  endtask

  initial begin
    idle(3);
    rd_en = 1'b1;
    #1 check("R7 reset ready", {31'b0, data_ready}, 32'd0);
    check("R9 reset bus", {16'b0, bus_out}, 32'd0);
    rd_en = 1'b0;
    rst_n = 1'b1;
    idle(25);

    // table walk: R3 R4 R5 R6
    foreach (VECS[i]) begin
      send_word(VECS[i][31:0], VECS[i][32]);
      read_check("R3 R4 R5 R6 vector", VECS[i][31:0], VECS[i][32]);
    end

    // R9 bus quiet while a word waits; R8 lower read keeps ready
    send_word(32'h1234_5678, 1'b0);
    #1 check("R9 bus quiet", {16'b0, bus_out}, 32'd0);
    @(negedge clk); rd_en = 1'b1; rd_sel = 1'b0;
    @(negedge clk); rd_en = 1'b0;
    @(negedge clk);
    check("R8 lower read keeps ready", {31'b0, data_ready}, 32'd1);
    read_check("R8 after lower", 32'h1234_5678, 1'b0);

    // R1 short pulses and R11 both-high add no bit
    len_short = 1'b1;
    @(negedge clk); rail_one = 1'b1;
    idle(2); rail_one = 1'b0; idle(8);
    @(negedge clk); rail_zero = 1'b1;
    idle(2); rail_zero = 1'b0; idle(8);
    @(negedge clk); rail_one = 1'b1; rail_zero = 1'b1;
    idle(5); rail_one = 1'b0; rail_zero = 1'b0; idle(5);
    send_word(32'h0155_AA33, 1'b1);
    read_check("R1 R11 glitch ignored", 32'h0155_AA33, 1'b1);

    // R2 partial word discarded by long null
    len_short = 1'b0;
    send_bits(32'h0000_03FF, 10);
    idle(40);
    check("R2 no word from partial", {31'b0, data_ready}, 32'd0);
    send_word(32'h7E00_0081, 1'b0);
    read_check("R2 after null", 32'h7E00_0081, 1'b0);

    // R10 overwrite an unread word
    send_word(32'h1111_1111, 1'b0);
    send_word(32'h2222_2223, 1'b0);
    read_check("R10 overwrite", 32'h2222_2223, 1'b0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule